// File: doc/BRIEF.md
# Row-locality-aware hybrid caching predictor

This block is the placement decision logic of a memory controller that fronts a small, fast DRAM cache and a large, slow non-volatile main memory. It watches the stream of requests to the slow memory. For each request it gets the row number and whether the access hit the open row buffer or forced a row-buffer conflict. It keeps a small table over a subset of rows. Each table entry counts how often its row is accessed and how often those accesses were conflicts. A row that is both reused and conflict-prone is worth moving into DRAM. A row that is streamed through the open row buffer stays where it is.

When both counts of a row rise above a shared threshold, the block raises a migrate request that carries the full row number. The request waits on a valid/ready handshake until the data mover accepts it. The row's entry is then dropped, so the same row is not requested twice. Migration itself is done elsewhere at 4 KB row granularity.

The threshold adapts once per fixed interval of clock cycles. The block weighs the conflicts that the interval's migrations are expected to save against a fixed cost per migration. It lowers the threshold when migrating paid off and raises it otherwise, within fixed limits.

Top module: `rowloc_predictor`

## Requirements
- R1: While reset is asserted, and on the first cycle after the two rising edges that complete its synchronised release, `mig_valid` is 0, `cur_thr` equals THR_INIT and every table entry is empty. The interval cycle count starts at 0 on that first cycle.
- R2: The table is direct-mapped and indexed by the low IDX_W bits of `req_row`; the remaining bits form the tag. When a request finds the entry empty or holding another tag, the entry takes the new tag with an access count of 1 and a conflict count of 1 when `req_conflict` is 1, else 0. Two rows that alternate on one index therefore never accumulate counts.
- R3: A request whose tag matches a valid entry adds 1 to its access count, and adds 1 to its conflict count only when `req_conflict` is 1 (1 = row-buffer conflict, 0 = open-row hit). Both counts saturate at 2^CNT_W-1.
- R4: If `mig_valid` is 0 and both updated counts are strictly greater than `cur_thr`, then `mig_valid` is 1 on the next cycle and `mig_row` carries the full `req_row`.
- R5: While `mig_valid` is 1 and `mig_ready` is 0, `mig_valid` stays 1 and `mig_row` stays unchanged. The cycle after `mig_valid` and `mig_ready` are both 1, `mig_valid` is 0, unless a new request is raised in that same cycle.
- R6: The entry of a row that raises a migrate request is emptied, so the next access to that row starts again from a count of 1. While a request is pending, no new one is raised, but the table keeps counting, and a row above threshold is raised on its first access after the pending one is accepted.
- R7: Every INTERVAL cycles the threshold is re-evaluated. The benefit is the sum of the conflict counts of the rows raised during the interval. The cost is the number of rows raised times MIG_WEIGHT. The threshold falls by 1 when benefit > cost and otherwise rises by 1, so an interval with no migration raises it.
- R8: `cur_thr` never leaves the range THR_MIN..THR_MAX (1..15); it changes by at most 1, and only on interval ends.
- R9: A migrate request raised in the last cycle of an interval is judged against the threshold in force before the update. Its conflict count and its cost are charged to the next interval.
- R10: A row accessed only with open-row hits never raises a migrate request, however often it is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchroniser |
| req_valid | input | 1 | A slow-memory request is presented this cycle |
| req_row | input | ROW_W | Row number of the request |
| req_conflict | input | 1 | 1 = the request caused a row-buffer conflict, 0 = it hit the open row |
| mig_valid | output | 1 | Migrate request pending |
| mig_ready | input | 1 | Data mover accepts the pending migrate request |
| mig_row | output | ROW_W | Row number to migrate into the DRAM cache |
| cur_thr | output | THR_W | Threshold currently applied to both counts |

## Verification
The threshold update and the raising of a migrate request can land in the same cycle. In that cycle the decision must use the old threshold, and the new request must be charged to the next interval's tally (R9). The bench provokes this by tracking the interval position in its own arithmetic model. It starts a run of conflicting accesses to a fresh row timed so that the access crossing the threshold falls on the last cycle of an interval. It then checks that the request appears. It also checks that the next interval's update reflects the charged benefit and cost. The per-cycle model comparison judges every other place where the two coincide during a long sweep of conflict-heavy traffic.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

  typedef enum logic [1:0] {
    THR_HOLD = 2'd0,
    THR_DOWN = 2'd1,
    THR_UP   = 2'd2
  } thr_step_e;

endpackage

// File: rtl/rlp_track_table.sv
module rlp_track_table #(
  parameter int ROW_W = 20,
  parameter int IDX_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [ROW_W-1:0] lk_row,
  input  logic             lk_conflict,
  input  logic             drop,
  output logic [CNT_W-1:0] nx_acc,
  output logic [CNT_W-1:0] nx_conf
);

  localparam int NENT  = 1 << IDX_W;
  localparam int TAG_W = ROW_W - IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             vld_q  [NENT];
  logic [TAG_W-1:0] tag_q  [NENT];
  logic [CNT_W-1:0] acc_q  [NENT];
  logic [CNT_W-1:0] conf_q [NENT];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tg;
  logic             hit;
  logic [CNT_W-1:0] base_acc;
  logic [CNT_W-1:0] base_conf;

  always_comb begin
    idx       = lk_row[IDX_W-1:0];
    tg        = lk_row[ROW_W-1:IDX_W];
    hit       = vld_q[idx] && (tag_q[idx] == tg);
    base_acc  = hit ? acc_q[idx]  : '0;
    base_conf = hit ? conf_q[idx] : '0;
    nx_acc    = (base_acc == CNT_MAX) ? base_acc : base_acc + 1'b1;
    nx_conf   = (lk_conflict && (base_conf != CNT_MAX)) ? base_conf + 1'b1 : base_conf;
  end

  for (genvar gi = 0; gi < NENT; gi++) begin : g_ent
    logic wr_en;
    assign wr_en = lk_valid && (idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[gi] <= 1'b0;
      end else if (wr_en) begin
        vld_q[gi] <= !drop;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[gi]  <= tg;
        acc_q[gi]  <= nx_acc;
        conf_q[gi] <= nx_conf;
      end
    end
  end

endmodule

// File: rtl/rlp_thresh_ctrl.sv
module rlp_thresh_ctrl
  import rlp_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int THR_W      = 4,
  parameter int THR_MIN    = 1,
  parameter int THR_MAX    = 15,
  parameter int THR_INIT   = 4,
  parameter int INTERVAL   = 1024,
  parameter int MIG_WEIGHT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mig_fire,
  input  logic [CNT_W-1:0] mig_conf,
  output logic [THR_W-1:0] thr
);

  localparam int IVL_W  = $clog2(INTERVAL);
  localparam int MC_W   = $clog2(INTERVAL + 1);
  localparam int BEN_W  = CNT_W + MC_W;
  localparam int WT_W   = $clog2(MIG_WEIGHT + 1);
  localparam int COST_W = MC_W + WT_W;
  localparam int CMP_W  = BEN_W + COST_W;

  logic [IVL_W-1:0]  ivl_q, ivl_d;
  logic [BEN_W-1:0]  ben_q, ben_d;
  logic [MC_W-1:0]   mcnt_q, mcnt_d;
  logic [THR_W-1:0]  thr_q, thr_d;
  logic [COST_W-1:0] cost;
  logic              boundary;
  thr_step_e         step;

  always_comb begin
    boundary = (ivl_q == IVL_W'(INTERVAL - 1));
    cost     = COST_W'(mcnt_q) * COST_W'(MIG_WEIGHT);
    if (!boundary)                             step = THR_HOLD;
    else if (CMP_W'(ben_q) > CMP_W'(cost))     step = THR_DOWN;
    else                                       step = THR_UP;

    thr_d = thr_q;
    case (step)
      THR_DOWN: if (thr_q > THR_W'(THR_MIN)) thr_d = thr_q - 1'b1;
      THR_UP:   if (thr_q < THR_W'(THR_MAX)) thr_d = thr_q + 1'b1;
      default:  thr_d = thr_q;
    endcase

    ivl_d  = boundary ? '0 : ivl_q + 1'b1;
    ben_d  = (boundary ? '0 : ben_q)  + (mig_fire ? BEN_W'(mig_conf) : '0);
    mcnt_d = (boundary ? '0 : mcnt_q) + (mig_fire ? MC_W'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      ben_q  <= '0;
      mcnt_q <= '0;
      thr_q  <= THR_W'(THR_INIT);
    end else begin
      ivl_q  <= ivl_d;
      ben_q  <= ben_d;
      mcnt_q <= mcnt_d;
      thr_q  <= thr_d;
    end
  end

  assign thr = thr_q;

endmodule

// File: rtl/rlp_mig_port.sv
module rlp_mig_port #(
  parameter int ROW_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic             ready,
  output logic             valid,
  output logic [ROW_W-1:0] row
);

  logic             vld_d;
  logic             row_en;

  always_comb begin
    row_en = load;
    if (load)               vld_d = 1'b1;
    else if (valid && ready) vld_d = 1'b0;
    else                    vld_d = valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (row_en) row <= load_row;
  end

endmodule

// File: rtl/rowloc_predictor.sv
module rowloc_predictor #(
  parameter int ROW_W      = 20,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 6,
  parameter int THR_W      = 4,
  parameter int THR_MIN    = 1,
  parameter int THR_MAX    = 15,
  parameter int THR_INIT   = 4,
  parameter int INTERVAL   = 1024,
  parameter int MIG_WEIGHT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_conflict,
  output logic             mig_valid,
  input  logic             mig_ready,
  output logic [ROW_W-1:0] mig_row,
  output logic [THR_W-1:0] cur_thr
);

  logic             rs1_q, rst_q;
  logic [CNT_W-1:0] nx_acc, nx_conf;
  logic [CNT_W-1:0] thr_ext;
  logic             issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_q <= rs1_q;
    end
  end

  always_comb begin
    thr_ext = CNT_W'(cur_thr);
    issue   = req_valid && !mig_valid && (nx_acc > thr_ext) && (nx_conf > thr_ext);
  end

  rlp_track_table #(
    .ROW_W(ROW_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_q),
    .lk_valid    (req_valid),
    .lk_row      (req_row),
    .lk_conflict (req_conflict),
    .drop        (issue),
    .nx_acc      (nx_acc),
    .nx_conf     (nx_conf)
  );

  rlp_thresh_ctrl #(
    .CNT_W(CNT_W), .THR_W(THR_W), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX),
    .THR_INIT(THR_INIT), .INTERVAL(INTERVAL), .MIG_WEIGHT(MIG_WEIGHT)
  ) u_thresh (
    .clk      (clk),
    .rst_n    (rst_q),
    .mig_fire (issue),
    .mig_conf (nx_conf),
    .thr      (cur_thr)
  );

  rlp_mig_port #(
    .ROW_W(ROW_W)
  ) u_port (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (issue),
    .load_row (req_row),
    .ready    (mig_ready),
    .valid    (mig_valid),
    .row      (mig_row)
  );

endmodule

// File: rtl/rowloc_predictor_chk.sv
module rowloc_predictor_chk #(
  parameter int ROW_W    = 20,
  parameter int THR_W    = 4,
  parameter int THR_MIN  = 1,
  parameter int THR_MAX  = 15,
  parameter int INTERVAL = 1024
) (
  input logic             clk,
  input logic             rst_q,
  input logic             req_valid,
  input logic [ROW_W-1:0] req_row,
  input logic             mig_valid,
  input logic             mig_ready,
  input logic [ROW_W-1:0] mig_row,
  input logic [THR_W-1:0] cur_thr
);

  localparam int IVL_W = $clog2(INTERVAL);

  logic [IVL_W-1:0] ivl_c;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)                              ivl_c <= '0;
    else if (ivl_c == IVL_W'(INTERVAL - 1))  ivl_c <= '0;
    else                                     ivl_c <= ivl_c + 1'b1;
  end

  // R4: a new request follows a presented access and names its row
  assert_mig_from_req_R4: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(mig_valid) |-> ($past(req_valid) && (mig_row == $past(req_row))));

  // R5: a pending request is held with its row until accepted
  assert_mig_hold_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_row)));

  // R8: threshold inside its limits
  assert_thr_range_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (cur_thr >= THR_W'(THR_MIN)) && (cur_thr <= THR_W'(THR_MAX)));

  // R8: threshold moves by one step at most
  assert_thr_step_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (cur_thr != $past(cur_thr)) |->
      ((cur_thr == $past(cur_thr) + 1'b1) || (cur_thr == $past(cur_thr) - 1'b1)));

  // R7: threshold changes only after the last cycle of an interval
  assert_thr_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (cur_thr != $past(cur_thr)) |-> ($past(ivl_c) == IVL_W'(INTERVAL - 1)));

endmodule

bind rowloc_predictor rowloc_predictor_chk #(
  .ROW_W(ROW_W), .THR_W(THR_W), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX), .INTERVAL(INTERVAL)
) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .req_valid (req_valid),
  .req_row   (req_row),
  .mig_valid (mig_valid),
  .mig_ready (mig_ready),
  .mig_row   (mig_row),
  .cur_thr   (cur_thr)
);

// File: tb/rowloc_predictor_tb.sv
`timescale 1ns/1ps
module rowloc_predictor_tb;

  localparam int ROW_W = 12, IDX_W = 4, CNT_W = 6, THR_W = 4;
  localparam int TMIN = 1, TMAX = 15, TINIT = 4, IVL = 32, WGT = 2;
  localparam int NENT = 1 << IDX_W;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic req_conflict = 1'b0;
  logic mig_ready = 1'b0;
  logic mig_valid;
  logic [ROW_W-1:0] mig_row;
  logic [THR_W-1:0] cur_thr;

  always #2.5 clk = ~clk;

  rowloc_predictor #(
    .ROW_W(ROW_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .THR_W(THR_W), .THR_MIN(TMIN),
    .THR_MAX(TMAX), .THR_INIT(TINIT), .INTERVAL(IVL), .MIG_WEIGHT(WGT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_conflict(req_conflict), .mig_valid(mig_valid), .mig_ready(mig_ready),
    .mig_row(mig_row), .cur_thr(cur_thr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- arithmetic reference model ----------------
  logic m_rs1 = 1'b0, m_rs2 = 1'b0;
  bit   m_vld [NENT];
  int   m_tag [NENT], m_acc [NENT], m_conf [NENT];
  int   m_thr, m_ivl, m_ben, m_mc, m_mrow, coinc;
  bit   m_mv;
  int   na, nc, mi;
  bit   mhit, miss_q, old_mv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_rs1 <= 1'b0; m_rs2 <= 1'b0; end
    else begin m_rs1 <= 1'b1; m_rs2 <= m_rs1; end
  end

  always @(posedge clk) begin
    if (!m_rs2) begin
      for (int i = 0; i < NENT; i++) m_vld[i] = 1'b0;
      m_thr = TINIT; m_ivl = 0; m_ben = 0; m_mc = 0; m_mv = 1'b0; m_mrow = 0;
    end else begin
      old_mv = m_mv;
      miss_q = 1'b0;
      na = 0; nc = 0;
      if (req_valid) begin
        mi   = int'(req_row) % NENT;
        mhit = m_vld[mi] && (m_tag[mi] == int'(req_row) / NENT);
        na   = mhit ? m_acc[mi] : 0;
        nc   = mhit ? m_conf[mi] : 0;
        if (na < CMAX) na++;
        if (req_conflict && nc < CMAX) nc++;
        miss_q = !old_mv && (na > m_thr) && (nc > m_thr);
        m_vld[mi]  = !miss_q;
        m_tag[mi]  = int'(req_row) / NENT;
        m_acc[mi]  = na;
        m_conf[mi] = nc;
      end
      if (m_ivl == IVL - 1) begin
        if (m_ben > m_mc * WGT) begin if (m_thr > TMIN) m_thr--; end
        else begin if (m_thr < TMAX) m_thr++; end
        m_ben = miss_q ? nc : 0;
        m_mc  = miss_q ? 1 : 0;
        m_ivl = 0;
        if (miss_q) coinc++;
      end else begin
        if (miss_q) begin m_ben += nc; m_mc++; end
        m_ivl++;
      end
      if (miss_q) begin m_mv = 1'b1; m_mrow = int'(req_row); end
      else if (old_mv && mig_ready) m_mv = 1'b0;
    end
  end

  // per-cycle comparison, plus a few observers
  bit prev_mv = 1'b0;
  int rises = 0;
  int min_thr = 99;
  always @(negedge clk) begin
    if (m_rs2) begin
      chk(mig_valid == m_mv, "R4 model mig_valid", int'(mig_valid), int'(m_mv));
      if (m_mv) chk(int'(mig_row) == m_mrow, "R5 model mig_row", int'(mig_row), m_mrow);
      chk(int'(cur_thr) == m_thr, "R7 model cur_thr", int'(cur_thr), m_thr);
      if (mig_valid && !prev_mv) rises++;
      if (int'(cur_thr) < min_thr) min_thr = int'(cur_thr);
    end
    prev_mv = mig_valid;
  end

  // ---------------- stimulus ----------------
  bit s_mv;
  logic [ROW_W-1:0] s_row;

  task automatic drive(input bit v, input int row, input bit c);
    @(negedge clk);
    s_mv  = mig_valid;
    s_row = mig_row;
    req_valid    = v;
    req_row      = ROW_W'(row);
    req_conflict = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int t, ta;

  initial begin
    coinc = 0;
    repeat (3) @(negedge clk);
    chk(mig_valid == 1'b0, "R1 reset mig_valid", int'(mig_valid), 0);
    chk(int'(cur_thr) == TINIT, "R1 reset cur_thr", int'(cur_thr), TINIT);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(cur_thr) == TINIT, "R1 cur_thr after release", int'(cur_thr), TINIT);

    // R10: streaming row, hits only
    rises = 0;
    for (int k = 0; k < 80; k++) drive(1, 12'h101, 0);
    drive(0, 0, 0);
    chk(rises == 0, "R10 streaming raised no request", rises, 0);

    // R2: two rows alternating on one index never build counts
    rises = 0;
    for (int k = 0; k < 60; k++) drive(1, (k % 2) ? 12'h112 : 12'h212, 1);
    drive(0, 0, 0);
    chk(rises == 0, "R2 aliasing rows raised no request", rises, 0);

    // R4/R3: a conflicting row crosses threshold on access t+1
    mig_ready = 1'b0;
    while (m_ivl != 0) @(negedge clk);
    t = int'(cur_thr);
    for (int k = 1; k <= t + 1; k++) begin
      drive(1, 12'h203, 1);
      if (k == t + 1) chk(s_mv == 1'b0, "R4 no request after access t", int'(s_mv), 0);
    end
    drive(0, 0, 0);
    chk(s_mv == 1'b1, "R4 request after access t+1", int'(s_mv), 1);
    chk(s_row == 12'h203, "R4 request row", int'(s_row), 'h203);

    // R5/R6: held while not ready; other row counts meanwhile
    for (int k = 0; k < 17; k++) drive(1, 12'h304, 1);
    drive(0, 0, 0);
    chk(s_mv == 1'b1, "R5 request held", int'(s_mv), 1);
    chk(s_row == 12'h203, "R5 row held / R6 no second request", int'(s_row), 'h203);
    mig_ready = 1'b1;
    drive(0, 0, 0);
    mig_ready = 1'b0;
    drive(1, 12'h304, 1);
    drive(0, 0, 0);
    chk(s_mv == 1'b1 && s_row == 12'h304, "R6 counts kept while busy", int'(s_row), 'h304);
    mig_ready = 1'b1;
    drive(0, 0, 0);
    drive(1, 12'h203, 1);
    drive(0, 0, 0);
    chk(s_mv == 1'b0, "R6 entry emptied after request", int'(s_mv), 0);

    // R9: crossing access lands on the last cycle of an interval
    t = int'(cur_thr);
    while (m_ivl != IVL - 2 - t) @(negedge clk);
    coinc = 0;
    for (int k = 0; k <= t; k++) drive(1, 12'h455, 1);
    drive(0, 0, 0);
    chk(s_mv == 1'b1, "R9 request on interval end", int'(s_mv), 1);
    chk(coinc == 1, "R9 boundary coincidence provoked", coinc, 1);
    ta = int'(cur_thr);
    repeat (IVL) drive(0, 0, 0);
    if (t + 1 > WGT)
      chk(int'(cur_thr) == ta - 1, "R9 charged to next interval", int'(cur_thr), ta - 1);

    // R7/R8: sustained conflict-heavy traffic drives threshold to its floor
    min_thr = 99;
    for (int r = 0; r < 120; r++)
      for (int j = 0; j < 16; j++) drive(1, 12'h600 + r, 1);
    drive(0, 0, 0);
    chk(int'(cur_thr) <= 2, "R7 threshold lowered by productive intervals", int'(cur_thr), 2);
    chk(min_thr == TMIN, "R8 floor reached and held", min_thr, TMIN);

    // R7/R8: idle intervals raise it to the ceiling and it stays
    repeat (IVL * 20) drive(0, 0, 0);
    chk(int'(cur_thr) == TMAX, "R8 ceiling after idle", int'(cur_thr), TMAX);

    // R3: saturation of counts with a request pending
    mig_ready = 1'b0;
    for (int k = 0; k < 16; k++) drive(1, 12'h701, 1);
    for (int k = 0; k < 70; k++) drive(1, 12'h702, 1);
    mig_ready = 1'b1;
    drive(0, 0, 0);
    drive(1, 12'h702, 1);
    drive(0, 0, 0);
    chk(s_mv == 1'b1 && s_row == 12'h702, "R3 saturated row raised", int'(s_row), 'h702);
    repeat (IVL * 2) drive(0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule